// File: doc/BRIEF.md
# Link Wake Request Generator

This block lives inside a serial-bus physical-layer device and wakes a powered-down link-layer controller. While hardware reset is held it keeps its wake pin undriven and reads two configuration straps through a short synchronizer. One strap gives the default bus-manager contender status. The other fills a two-bit bridge-capability field with all zeros or all ones. A later write can replace that field.

After reset the block watches link activity, which is the link power status input together with the link-control register bit. It also watches a one-cycle pulse for a wake packet addressed to this node, a set of interrupt register bits and bus-reset events. When the link is asleep and a wake cause appears, the block latches a wake request. It drives the wake pin as a square wave with a period of eight clocks, four cycles high and four low, starting high. The request stays latched until the link reports itself active. A bus reset cancels a request that came only from a packet. A request backed by a qualifying interrupt condition survives the bus reset.

Top module: `link_wake_gen`

## Requirements
- R1: While `rst_n` is low, `wake_oe_o` and `wake_o` are 0. After reset is released, `wake_oe_o` is 1.
- R2: After reset, `contender_o` equals the level that `strap_contend_i` held during the final clocks of reset. It does not follow later changes of that input.
- R3: After reset, `bridge_aware_o` is 2'b00 if `strap_bridge_i` was low during reset, and 2'b11 if it was high.
- R4: After reset, a cycle with `bridge_wr_i`=1 loads `bridge_wdata_i` into `bridge_aware_o` at that clock edge. Without a write the field holds its value.
- R5: A `pkt_wake_i` pulse while the link is inactive makes `wake_o` go high after the next clock edge. It then repeats 4 cycles high and 4 cycles low.
- R6: `irq_port_evt_i`=1 triggers a wake by itself. `irq_cfg_to_i`, `irq_cpwr_i` and `irq_st_to_i` trigger a wake only while `resume_en_i`=1.
- R7: The link is active only when `lps_i` and `lctrl_i` are both 1. While it is active, `wake_o` is 0 from the next cycle on and no trigger starts a wake. With either signal at 0, triggers are accepted.
- R8: Once a wake has started, it continues after its trigger goes away, until the link becomes active.
- R9: A `bus_rst_i` pulse ends a wake from the next cycle when no qualifying interrupt condition holds in that cycle. Otherwise the square wave continues without a phase restart.
- R10: If a qualifying interrupt condition is present when the link goes from active to inactive, `wake_o` goes high in the next cycle and starts a fresh period.
- R11: A `pkt_wake_i` pulse in the same cycle as `bus_rst_i` is discarded. No wake starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low |
| strap_contend_i | input | 1 | Contender strap level, read during reset |
| strap_bridge_i | input | 1 | Bridge-capability strap, read during reset |
| lps_i | input | 1 | Link power status, 1 = powered |
| lctrl_i | input | 1 | Link-control register bit |
| pkt_wake_i | input | 1 | One-cycle pulse: wake packet for this node received |
| irq_port_evt_i | input | 1 | Port-event interrupt bit |
| irq_cfg_to_i | input | 1 | Configuration-timeout interrupt bit |
| irq_cpwr_i | input | 1 | Cable-power-status interrupt bit |
| irq_st_to_i | input | 1 | State-timeout interrupt bit |
| resume_en_i | input | 1 | Resuming-port interrupt enable bit |
| bus_rst_i | input | 1 | One-cycle bus-reset event |
| bridge_wr_i | input | 1 | Register write strobe for the bridge field |
| bridge_wdata_i | input | 2 | Write data for the bridge field |
| contender_o | output | 1 | Captured contender status |
| bridge_aware_o | output | 2 | Bridge-capability field |
| wake_o | output | 1 | Wake square wave |
| wake_oe_o | output | 1 | Output enable for the wake pin |

## Verification
A bus reset can arrive in the same cycle as a wake-packet pulse, or while an interrupt condition is pending. Both cases decide whether a wake survives. The bench drives the packet pulse and the bus-reset pulse on the same clock edge and expects the wake pin to stay low for a full period. In a separate case it issues a bus reset during an interrupt-driven wake and expects the square wave to keep toggling with four high samples in the next eight. A second overlap is a link that drops to inactive while an interrupt is already pending. There the bench expects the pin to go high in the very next cycle.

// File: rtl/lw_pkg.sv
package lw_pkg;

   typedef struct packed {
      logic port_evt;
      logic cfg_to;
      logic cpwr;
      logic st_to;
      logic resume_en;
   } lw_irq_t;

   // A wake is wanted from the interrupt side when the port event is set,
   // or when a resumable condition is set and resuming is enabled.
   function automatic logic lw_irq_wants_wake(input lw_irq_t irq);
      return irq.port_evt | (irq.resume_en & (irq.cfg_to | irq.cpwr | irq.st_to));
   endfunction

endpackage

// File: rtl/lw_strap_capture.sv
module lw_strap_capture #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BRIDGE_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                strap_contend_i,
   input  logic                strap_bridge_i,
   input  logic                wr_i,
   input  logic [BRIDGE_W-1:0] wdata_i,
   output logic                contender_o,
   output logic [BRIDGE_W-1:0] bridge_o
);
   localparam int unsigned NSTRAP = 2;

   logic [NSTRAP-1:0] chain [SYNC_STAGES];
   logic [NSTRAP-1:0] synced;

   always_ff @(posedge clk) begin
      chain[0] <= {strap_bridge_i, strap_contend_i};
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         chain[s] <= chain[s-1];
      end
   end

   assign synced = chain[SYNC_STAGES-1];

   // The straps are loaded on every clock while reset is held, so the last
   // clock before release decides the value.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         contender_o <= synced[0];
         bridge_o    <= {BRIDGE_W{synced[1]}};
      end else if (wr_i) begin
         bridge_o    <= wdata_i;
      end
   end
endmodule

// File: rtl/lw_wake_ctrl.sv
module lw_wake_ctrl
   import lw_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    link_active_i,
   input  logic    pkt_wake_i,
   input  lw_irq_t irq_i,
   input  logic    bus_rst_i,
   output logic    active_o
);
   logic irq_want;
   logic active_d;

   assign irq_want = lw_irq_wants_wake(irq_i);

   always_comb begin
      if (link_active_i)  active_d = 1'b0;
      else if (bus_rst_i) active_d = irq_want;
      else                active_d = active_o | irq_want | pkt_wake_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_o <= 1'b0;
      else        active_o <= active_d;
   end
endmodule

// File: rtl/lw_square_gen.sv
module lw_square_gen #(
   parameter int unsigned PHASE_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   output logic wave_o
);
   logic [PHASE_W-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         phase <= '0;
      else if (!active_i) phase <= '0;
      else                phase <= phase + 1'b1;
   end

   assign wave_o = active_i & ~phase[PHASE_W-1];
endmodule

// File: rtl/link_wake_gen.sv
module link_wake_gen
   import lw_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PHASE_W     = 3,
   parameter int unsigned BRIDGE_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                strap_contend_i,
   input  logic                strap_bridge_i,
   input  logic                lps_i,
   input  logic                lctrl_i,
   input  logic                pkt_wake_i,
   input  logic                irq_port_evt_i,
   input  logic                irq_cfg_to_i,
   input  logic                irq_cpwr_i,
   input  logic                irq_st_to_i,
   input  logic                resume_en_i,
   input  logic                bus_rst_i,
   input  logic                bridge_wr_i,
   input  logic [BRIDGE_W-1:0] bridge_wdata_i,
   output logic                contender_o,
   output logic [BRIDGE_W-1:0] bridge_aware_o,
   output logic                wake_o,
   output logic                wake_oe_o
);
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("link_wake_gen: SYNC_STAGES must be at least 1");
   end
   if (PHASE_W < 1) begin : g_bad_phase
      $error("link_wake_gen: PHASE_W must be at least 1");
   end
   if (BRIDGE_W < 1) begin : g_bad_bridge
      $error("link_wake_gen: BRIDGE_W must be at least 1");
   end

   lw_irq_t irq;
   logic    link_active;
   logic    active;

   assign irq = '{port_evt: irq_port_evt_i, cfg_to: irq_cfg_to_i,
                  cpwr: irq_cpwr_i, st_to: irq_st_to_i, resume_en: resume_en_i};
   assign link_active = lps_i & lctrl_i;
   assign wake_oe_o   = rst_n;

   lw_strap_capture #(.SYNC_STAGES(SYNC_STAGES), .BRIDGE_W(BRIDGE_W)) u_strap (
      .clk            (clk),
      .rst_n          (rst_n),
      .strap_contend_i(strap_contend_i),
      .strap_bridge_i (strap_bridge_i),
      .wr_i           (bridge_wr_i),
      .wdata_i        (bridge_wdata_i),
      .contender_o    (contender_o),
      .bridge_o       (bridge_aware_o)
   );

   lw_wake_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .link_active_i(link_active),
      .pkt_wake_i   (pkt_wake_i),
      .irq_i        (irq),
      .bus_rst_i    (bus_rst_i),
      .active_o     (active)
   );

   lw_square_gen #(.PHASE_W(PHASE_W)) u_sq (
      .clk     (clk),
      .rst_n   (rst_n),
      .active_i(active),
      .wave_o  (wake_o)
   );
endmodule

// File: rtl/link_wake_gen_chk.sv
module link_wake_gen_chk #(
   parameter int unsigned BRIDGE_W = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                lps_i,
   input logic                lctrl_i,
   input logic                irq_port_evt_i,
   input logic                irq_cfg_to_i,
   input logic                irq_cpwr_i,
   input logic                irq_st_to_i,
   input logic                resume_en_i,
   input logic                bus_rst_i,
   input logic                bridge_wr_i,
   input logic                contender_o,
   input logic [BRIDGE_W-1:0] bridge_aware_o,
   input logic                wake_o
);
   p_link_active_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lps_i && lctrl_i) |=> !wake_o);

   p_contender_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(contender_o));

   p_bridge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bridge_wr_i |=> $stable(bridge_aware_o));

   p_bus_rst_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rst_i && !irq_port_evt_i &&
       !(resume_en_i && (irq_cfg_to_i || irq_cpwr_i || irq_st_to_i))) |=> !wake_o);

   p_first_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wake_o) && !(lps_i && lctrl_i) && !bus_rst_i) |=> wake_o);
endmodule

bind link_wake_gen link_wake_gen_chk #(.BRIDGE_W(BRIDGE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lps_i         (lps_i),
   .lctrl_i       (lctrl_i),
   .irq_port_evt_i(irq_port_evt_i),
   .irq_cfg_to_i  (irq_cfg_to_i),
   .irq_cpwr_i    (irq_cpwr_i),
   .irq_st_to_i   (irq_st_to_i),
   .resume_en_i   (resume_en_i),
   .bus_rst_i     (bus_rst_i),
   .bridge_wr_i   (bridge_wr_i),
   .contender_o   (contender_o),
   .bridge_aware_o(bridge_aware_o),
   .wake_o        (wake_o)
);

// File: tb/link_wake_gen_tb_top.sv
module link_wake_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap_contend_i = 1'b0, strap_bridge_i = 1'b0;
   logic       lps_i = 1'b0, lctrl_i = 1'b0, pkt_wake_i = 1'b0;
   logic       irq_port_evt_i = 1'b0, irq_cfg_to_i = 1'b0, irq_cpwr_i = 1'b0;
   logic       irq_st_to_i = 1'b0, resume_en_i = 1'b0, bus_rst_i = 1'b0;
   logic       bridge_wr_i = 1'b0;
   logic [1:0] bridge_wdata_i = 2'b00;
   logic       contender_o, wake_o, wake_oe_o;
   logic [1:0] bridge_aware_o;

   int vectors = 0;
   int miss = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   link_wake_gen dut_i (.*);

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_wave(input string tag, input int n);
      for (int i = 0; i < n; i++) begin
         chk(tag, {7'd0, wake_o}, ((i % 8) < 4) ? 8'd1 : 8'd0);
         @(negedge clk);
      end
   endtask

   task automatic chk_quiet(input string tag, input int n);
      for (int i = 0; i < n; i++) begin
         chk(tag, {7'd0, wake_o}, 8'd0);
         @(negedge clk);
      end
   endtask

   task automatic pulse_pkt();
      pkt_wake_i = 1'b1;
      @(negedge clk);
      pkt_wake_i = 1'b0;
   endtask

   task automatic settle_link();
      lps_i = 1'b1; lctrl_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      lps_i = 1'b0; lctrl_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_reset(input logic cont, input logic br);
      rst_n = 1'b0;
      strap_contend_i = cont;
      strap_bridge_i  = br;
      for (int i = 0; i < 5; i++) @(negedge clk);
      chk("R1 oe in reset", {7'd0, wake_oe_o}, 8'd0);
      chk("R1 wake in reset", {7'd0, wake_o}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 oe after reset", {7'd0, wake_oe_o}, 8'd1);
      chk("R1 wake after reset", {7'd0, wake_o}, 8'd0);
   endtask

   task automatic t_straps_a();
      do_reset(1'b1, 1'b0);
      chk("R2 contender", {7'd0, contender_o}, 8'd1);
      chk("R3 bridge low strap", {6'd0, bridge_aware_o}, 8'd0);
      strap_contend_i = 1'b0; strap_bridge_i = 1'b1;
      for (int i = 0; i < 4; i++) @(negedge clk);
      chk("R2 contender held", {7'd0, contender_o}, 8'd1);
      chk("R3 bridge held", {6'd0, bridge_aware_o}, 8'd0);
   endtask

   task automatic t_straps_b();
      do_reset(1'b0, 1'b1);
      chk("R2 contender low", {7'd0, contender_o}, 8'd0);
      chk("R3 bridge high strap", {6'd0, bridge_aware_o}, 8'd3);
      bridge_wdata_i = 2'b01; bridge_wr_i = 1'b1;
      @(negedge clk);
      bridge_wr_i = 1'b0; bridge_wdata_i = 2'b10;
      chk("R4 bridge write", {6'd0, bridge_aware_o}, 8'd1);
      @(negedge clk);
      chk("R4 bridge hold", {6'd0, bridge_aware_o}, 8'd1);
   endtask

   task automatic t_packet();
      pulse_pkt();
      chk_wave("R5 packet wave", 16);
      chk_wave("R8 packet latched", 8);
      lps_i = 1'b1; lctrl_i = 1'b1;
      @(negedge clk);
      chk_quiet("R7 link active clears", 4);
      pulse_pkt();
      chk_quiet("R7 packet ignored while active", 8);
      lctrl_i = 1'b0;
      pulse_pkt();
      chk_wave("R7 lctrl low is inactive", 8);
      settle_link();
   endtask

   task automatic t_irq();
      irq_cfg_to_i = 1'b1; irq_cpwr_i = 1'b1; irq_st_to_i = 1'b1;
      @(negedge clk);
      chk_quiet("R6 no enable no wake", 8);
      resume_en_i = 1'b1;
      @(negedge clk);
      irq_cfg_to_i = 1'b0; irq_cpwr_i = 1'b0; irq_st_to_i = 1'b0; resume_en_i = 1'b0;
      chk_wave("R6 enabled timeout wakes", 8);
      chk_wave("R8 irq cleared still waking", 8);
      settle_link();
      irq_port_evt_i = 1'b1;
      @(negedge clk);
      irq_port_evt_i = 1'b0;
      chk_wave("R6 port event wakes", 8);
      settle_link();
   endtask

   task automatic t_bus_reset();
      int highs;
      pulse_pkt();
      chk_wave("R5 before bus reset", 3);
      bus_rst_i = 1'b1;
      @(negedge clk);
      bus_rst_i = 1'b0;
      chk_quiet("R9 packet-only wake dropped", 10);
      irq_port_evt_i = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 3; i++) @(negedge clk);
      bus_rst_i = 1'b1;
      @(negedge clk);
      bus_rst_i = 1'b0;
      highs = 0;
      for (int i = 0; i < 8; i++) begin
         highs += int'(wake_o);
         @(negedge clk);
      end
      chk("R9 irq wake survives bus reset", 8'(highs), 8'd4);
      irq_port_evt_i = 1'b0;
      settle_link();
   endtask

   task automatic t_link_drop();
      lps_i = 1'b1; lctrl_i = 1'b1; irq_port_evt_i = 1'b1;
      @(negedge clk);
      chk_quiet("R7 pending irq while active", 5);
      lps_i = 1'b0;
      @(negedge clk);
      chk_wave("R10 wake on link drop", 8);
      irq_port_evt_i = 1'b0;
      settle_link();
   endtask

   task automatic t_coincide();
      pkt_wake_i = 1'b1; bus_rst_i = 1'b1;
      @(negedge clk);
      pkt_wake_i = 1'b0; bus_rst_i = 1'b0;
      chk_quiet("R11 packet with bus reset dropped", 10);
   endtask

   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         miss++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_straps_a();
      t_straps_b();
      t_packet();
      t_irq();
      t_bus_reset();
      t_link_drop();
      t_coincide();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
   end
endmodule